// File: doc/BRIEF.md
# SIMT Warp Issue Scheduler

This block sits at the front of a multithreaded shader core and decides, once per issue window, which resident warp sends its next instruction into the execution lanes. Each resident warp presents a valid flag, the destination and two source register tags of its pending instruction, and a per-thread activity mask. A per-warp pending-write table marks registers whose results are still in flight. A warp may issue only when none of its three tags is marked. Dependences are tracked within one warp and never between warps. Result writebacks clear the table one entry at a time.

An issue window is four clocks long and is driven by a four-state machine: `SLOT_0 -> SLOT_1 -> SLOT_2 -> SLOT_3 -> SLOT_0`. Each transition is taken unconditionally on every clock. The choice is made on the clock edge that leaves `SLOT_3`, and that edge also enters `SLOT_0`. The winner's instruction then plays out across the four slots as four slices of `LANE_GROUP` threads, one slice per clock. A slice goes only to threads whose activity bit is set. A rotating priority pointer keeps the choice fair. Reset puts the machine in `SLOT_3` with no instruction held, so the first choice is made on the first clock edge after reset is released.

Top module: `warp_issue_sched`

## Requirements
- R1: While reset is asserted, and on the first clock after it is released, `issue_valid` is 0, `lane_mask` is 0 and `slice_idx` is 3.
- R2: `slice_idx` steps 0, 1, 2, 3 and back to 0 on every clock. One choice is made per four clocks. `issue_valid` is 1 only in slot 0, so two issues are never on adjacent clocks.
- R3: In slot k, `lane_mask` equals bits `[k*LANE_GROUP +: LANE_GROUP]` of the chosen warp's `thread_mask`, as sampled at the choice edge. Bit 0 of each slice is the lowest thread of that slice. A slice whose bits are all zero still occupies its clock, and so does an issue whose whole mask is zero.
- R4: A warp is eligible only if its `warp_valid` bit is 1 and none of its destination, source A or source B tags is marked pending in its own table.
- R5: Issuing a warp marks its destination tag pending for that warp. A writeback (`wb_valid`, `wb_warp`, `wb_reg`) clears only the entry with that warp and tag. A writeback captured on the choice edge itself does not affect that choice; it counts from the next choice on.
- R6: A tag pending for one warp never blocks another warp that names the same tag.
- R7: Priority rotates. After reset the pointer is warp 0. The winner is the first eligible warp at or after the pointer, counting upward and wrapping modulo `NUM_WARPS`. After an issue, the pointer moves to the winner plus one, wrapping.
- R8: When no warp is eligible, the window is a bubble: `issue_valid` is 0 and `lane_mask` is 0 for all four slots, and the pointer keeps its value.
- R9: `issue_warp` and `issue_tag` hold the winner's ID and destination tag, unchanged through slots 1 to 3 of its window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| warp_valid | input | NUM_WARPS | Warp w has a pending instruction |
| next_dst | input | NUM_WARPS*RW | Destination tag per warp, warp w at `[w*RW +: RW]` |
| next_src_a | input | NUM_WARPS*RW | First source tag per warp |
| next_src_b | input | NUM_WARPS*RW | Second source tag per warp |
| thread_mask | input | NUM_WARPS*WARP_SIZE | Active threads per warp, warp w at `[w*WARP_SIZE +: WARP_SIZE]` |
| wb_valid | input | 1 | A result writeback completes this clock |
| wb_warp | input | WW | Warp of the writeback |
| wb_reg | input | RW | Register tag of the writeback |
| issue_valid | output | 1 | An instruction starts this clock (slot 0) |
| issue_warp | output | WW | Warp of the current window |
| issue_tag | output | RW | Destination tag of the current window |
| lane_mask | output | LANE_GROUP | Threads acting in this clock's slice |
| slice_idx | output | 2 | Current slot of the window |

## Verification
The bench builds the scheduler with eight warps, eight register tags and eight-lane groups, which gives a 32-thread warp. With these sizes the priority pointer wraps after a few issues, and every resident warp can be blocked at the same time. This lets a short directed run reach bubbles, wrap-around choices and writebacks aimed at the wrong warp. Masks with empty slices and an all-zero mask are included to show that the window length never changes.

// File: rtl/warp_sched_pkg.sv
package warp_sched_pkg;

    // Number of lane-group slices one warp instruction is spread across.
    localparam int SLICES = 4;

    // Issue window phases; the choice is made on the edge leaving SLOT_3.
    typedef enum logic [1:0] {
        SLOT_0 = 2'd0,
        SLOT_1 = 2'd1,
        SLOT_2 = 2'd2,
        SLOT_3 = 2'd3
    } slot_e;

endpackage

// File: rtl/rr_picker.sv
module rr_picker #(
    parameter int N  = 16,
    parameter int IW = 4
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] ptr,
    output logic          gnt_valid,
    output logic [IW-1:0] gnt_idx
);

    // First requester at or above ptr, wrapping modulo N.
    always_comb begin
        int j;
        gnt_valid = 1'b0;
        gnt_idx   = '0;
        for (int k = 0; k < N; k++) begin
            j = int'(ptr) + k;
            if (j >= N) j = j - N;
            if (!gnt_valid && req[j]) begin
                gnt_valid = 1'b1;
                gnt_idx   = IW'(j);
            end
        end
    end

endmodule

// File: rtl/warp_scoreboard.sv
module warp_scoreboard #(
    parameter int NW = 16,
    parameter int NR = 16,
    parameter int WW = 4,
    parameter int RW = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           set_en,
    input  logic [WW-1:0]  set_warp,
    input  logic [RW-1:0]  set_reg,
    input  logic           clr_en,
    input  logic [WW-1:0]  clr_warp,
    input  logic [RW-1:0]  clr_reg,
    input  logic [NW*RW-1:0] q_dst,
    input  logic [NW*RW-1:0] q_src_a,
    input  logic [NW*RW-1:0] q_src_b,
    output logic [NW-1:0]  hazard
);

    for (genvar g = 0; g < NW; g++) begin : g_warp
        logic [NR-1:0] pend_q;

        // Clear first, then set: a same-cycle set of the same entry wins.
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pend_q <= '0;
            end else begin
                if (clr_en && clr_warp == WW'(g)) pend_q[clr_reg] <= 1'b0;
                if (set_en && set_warp == WW'(g)) pend_q[set_reg] <= 1'b1;
            end
        end

        assign hazard[g] = pend_q[q_dst[g*RW +: RW]]
                         | pend_q[q_src_a[g*RW +: RW]]
                         | pend_q[q_src_b[g*RW +: RW]];
    end

endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched
    import warp_sched_pkg::*;
#(
    parameter int NUM_WARPS  = 16,
    parameter int LANE_GROUP = 8,
    parameter int NUM_REGS   = 16,
    localparam int WARP_SIZE = SLICES * LANE_GROUP,
    localparam int WW        = $clog2(NUM_WARPS),
    localparam int RW        = $clog2(NUM_REGS)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_WARPS-1:0]           warp_valid,
    input  logic [NUM_WARPS*RW-1:0]        next_dst,
    input  logic [NUM_WARPS*RW-1:0]        next_src_a,
    input  logic [NUM_WARPS*RW-1:0]        next_src_b,
    input  logic [NUM_WARPS*WARP_SIZE-1:0] thread_mask,
    input  logic                           wb_valid,
    input  logic [WW-1:0]                  wb_warp,
    input  logic [RW-1:0]                  wb_reg,
    output logic                           issue_valid,
    output logic [WW-1:0]                  issue_warp,
    output logic [RW-1:0]                  issue_tag,
    output logic [LANE_GROUP-1:0]          lane_mask,
    output logic [1:0]                     slice_idx
);

    slot_e                 slot_q, slot_d;
    logic                  decide;
    logic [NUM_WARPS-1:0]  hazard;
    logic [NUM_WARPS-1:0]  eligible;
    logic                  pick_valid;
    logic [WW-1:0]         pick_idx;
    logic [RW-1:0]         pick_dst;
    logic [WW-1:0]         ptr_q;
    logic                  cur_valid;
    logic [WW-1:0]         cur_warp;
    logic [RW-1:0]         cur_tag;
    logic [WARP_SIZE-1:0]  cur_mask;
    logic [LANE_GROUP-1:0] slice_bits;

    // ---------------- phase state machine ----------------
    always_comb begin
        slot_d = slot_q;
        unique case (slot_q)
            SLOT_0: slot_d = SLOT_1;
            SLOT_1: slot_d = SLOT_2;
            SLOT_2: slot_d = SLOT_3;
            SLOT_3: slot_d = SLOT_0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) slot_q <= SLOT_3;
        else        slot_q <= slot_d;
    end

    assign decide = (slot_q == SLOT_3);

    // ---------------- readiness and choice ----------------
    warp_scoreboard #(
        .NW (NUM_WARPS),
        .NR (NUM_REGS),
        .WW (WW),
        .RW (RW)
    ) u_sb (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en   (decide && pick_valid),
        .set_warp (pick_idx),
        .set_reg  (pick_dst),
        .clr_en   (wb_valid),
        .clr_warp (wb_warp),
        .clr_reg  (wb_reg),
        .q_dst    (next_dst),
        .q_src_a  (next_src_a),
        .q_src_b  (next_src_b),
        .hazard   (hazard)
    );

    assign eligible = warp_valid & ~hazard;

    rr_picker #(
        .N  (NUM_WARPS),
        .IW (WW)
    ) u_pick (
        .req       (eligible),
        .ptr       (ptr_q),
        .gnt_valid (pick_valid),
        .gnt_idx   (pick_idx)
    );

    assign pick_dst = next_dst[pick_idx*RW +: RW];

    // ---------------- window registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q     <= '0;
            cur_valid <= 1'b0;
            cur_warp  <= '0;
            cur_tag   <= '0;
            cur_mask  <= '0;
        end else if (decide) begin
            cur_valid <= pick_valid;
            if (pick_valid) begin
                cur_warp <= pick_idx;
                cur_tag  <= pick_dst;
                cur_mask <= thread_mask[pick_idx*WARP_SIZE +: WARP_SIZE];
                ptr_q    <= (int'(pick_idx) == NUM_WARPS - 1) ? '0 : pick_idx + WW'(1);
            end
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        slice_bits = '0;
        unique case (slot_q)
            SLOT_0: slice_bits = cur_mask[0*LANE_GROUP +: LANE_GROUP];
            SLOT_1: slice_bits = cur_mask[1*LANE_GROUP +: LANE_GROUP];
            SLOT_2: slice_bits = cur_mask[2*LANE_GROUP +: LANE_GROUP];
            SLOT_3: slice_bits = cur_mask[3*LANE_GROUP +: LANE_GROUP];
        endcase
        lane_mask   = cur_valid ? slice_bits : '0;
        issue_valid = cur_valid && (slot_q == SLOT_0);
        issue_warp  = cur_warp;
        issue_tag   = cur_tag;
        slice_idx   = slot_q;
    end

endmodule

// File: rtl/warp_sched_chk.sv
module warp_sched_chk #(
    parameter int NUM_WARPS  = 16,
    parameter int LANE_GROUP = 8,
    parameter int WW         = 4,
    parameter int RW         = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NUM_WARPS-1:0]  warp_valid,
    input logic                  issue_valid,
    input logic [WW-1:0]         issue_warp,
    input logic [RW-1:0]         issue_tag,
    input logic [LANE_GROUP-1:0] lane_mask,
    input logic [1:0]            slice_idx
);

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!issue_valid && lane_mask == '0 && slice_idx == 2'd3));

    assert_slot_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        slice_idx == 2'd3 |=> slice_idx == 2'd0);

    assert_issue_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |=> !issue_valid);

    assert_from_valid_warp_R4: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> ((($past(warp_valid) >> issue_warp) & NUM_WARPS'(1)) != '0));

    assert_bubble_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (slice_idx == 2'd0 && !issue_valid) |-> lane_mask == '0);

    assert_bubble_tail_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (slice_idx == 2'd0 && !issue_valid) |=> lane_mask == '0);

    assert_hold_id_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (slice_idx != 2'd0) |-> ($stable(issue_warp) && $stable(issue_tag)));

endmodule

bind warp_issue_sched warp_sched_chk #(
    .NUM_WARPS  (NUM_WARPS),
    .LANE_GROUP (LANE_GROUP),
    .WW         (WW),
    .RW         (RW)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .warp_valid  (warp_valid),
    .issue_valid (issue_valid),
    .issue_warp  (issue_warp),
    .issue_tag   (issue_tag),
    .lane_mask   (lane_mask),
    .slice_idx   (slice_idx)
);

// File: tb/warp_issue_sched_tb.sv
module warp_issue_sched_tb;

    localparam int NW = 8;
    localparam int LG = 8;
    localparam int NR = 8;
    localparam int WS = 4 * LG;
    localparam int WW = $clog2(NW);
    localparam int RW = $clog2(NR);

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [NW-1:0]       warp_valid = '0;
    logic [NW*RW-1:0]    next_dst = '0;
    logic [NW*RW-1:0]    next_src_a = '0;
    logic [NW*RW-1:0]    next_src_b = '0;
    logic [NW*WS-1:0]    thread_mask = '0;
    logic                wb_valid = 1'b0;
    logic [WW-1:0]       wb_warp = '0;
    logic [RW-1:0]       wb_reg = '0;
    logic                issue_valid;
    logic [WW-1:0]       issue_warp;
    logic [RW-1:0]       issue_tag;
    logic [LG-1:0]       lane_mask;
    logic [1:0]          slice_idx;

    int n_cmp = 0;
    int n_bad = 0;
    logic mon_en = 1'b0;

    typedef struct {
        logic          v;
        logic [WW-1:0] w;
        logic [RW-1:0] t;
        logic [WS-1:0] m;
        string         req;
    } exp_t;

    exp_t exp_q[$];
    exp_t cur;

    always #4 clk = ~clk;   // 125 MHz

    warp_issue_sched #(
        .NUM_WARPS  (NW),
        .LANE_GROUP (LG),
        .NUM_REGS   (NR)
    ) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .warp_valid  (warp_valid),
        .next_dst    (next_dst),
        .next_src_a  (next_src_a),
        .next_src_b  (next_src_b),
        .thread_mask (thread_mask),
        .wb_valid    (wb_valid),
        .wb_warp     (wb_warp),
        .wb_reg      (wb_reg),
        .issue_valid (issue_valid),
        .issue_warp  (issue_warp),
        .issue_tag   (issue_tag),
        .lane_mask   (lane_mask),
        .slice_idx   (slice_idx)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    task automatic set_warp(input int w, input bit v, input int d, input int a,
                            input int b, input logic [WS-1:0] m);
        warp_valid[w]            = v;
        next_dst[w*RW +: RW]     = RW'(d);
        next_src_a[w*RW +: RW]   = RW'(a);
        next_src_b[w*RW +: RW]   = RW'(b);
        thread_mask[w*WS +: WS]  = m;
    endtask

    // Writeback driven from the current negedge for one clock edge.
    task automatic writeback(input int w, input int r);
        wb_valid = 1'b1;
        wb_warp  = WW'(w);
        wb_reg   = RW'(r);
        @(negedge clk);
        wb_valid = 1'b0;
    endtask

    // Driver: waits for the negedge before a choice edge, pushes the expected
    // window, optionally drives a writeback that lands on the choice edge.
    task automatic slot(input bit v, input int w, input int t,
                        input logic [WS-1:0] m, input string req,
                        input bit late_wb, input int wbw, input int wbr);
        exp_t e;
        while (slice_idx != 2'd3) @(negedge clk);
        e.v = v; e.w = WW'(w); e.t = RW'(t); e.m = v ? m : '0; e.req = req;
        exp_q.push_back(e);
        if (late_wb) begin
            wb_valid = 1'b1; wb_warp = WW'(wbw); wb_reg = RW'(wbr);
        end
        @(negedge clk);
        wb_valid = 1'b0;
    endtask

    // Monitor: pops one expected window per slot 0, checks every slice.
    always @(negedge clk) begin
        if (rst_n && mon_en) begin
            if (slice_idx == 2'd0) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2", "window with no expectation", 64'(issue_valid), 64'd0);
                end else begin
                    cur = exp_q.pop_front();
                    check(issue_valid == cur.v, cur.req, "issue_valid", 64'(issue_valid), 64'(cur.v));
                    if (cur.v) begin
                        check(issue_warp == cur.w, cur.req, "issue_warp", 64'(issue_warp), 64'(cur.w));
                        check(issue_tag == cur.t, cur.req, "issue_tag", 64'(issue_tag), 64'(cur.t));
                    end
                    check(lane_mask == cur.m[0 +: LG], cur.req, "lane_mask slot0",
                          64'(lane_mask), 64'(cur.m[0 +: LG]));
                end
            end else begin
                // R2: no issue outside slot 0; R3 slices; R9 identity held
                check(!issue_valid, "R2", "issue_valid off slot0", 64'(issue_valid), 64'd0);
                check(lane_mask == cur.m[int'(slice_idx)*LG +: LG], cur.req,
                      $sformatf("lane_mask slot%0d", slice_idx),
                      64'(lane_mask), 64'(cur.m[int'(slice_idx)*LG +: LG]));
                if (cur.v)
                    check(issue_warp == cur.w && issue_tag == cur.t, "R9", "held warp/tag",
                          {issue_warp, issue_tag}, {cur.w, cur.t});
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check(!issue_valid && lane_mask == '0, "R1", "outputs in reset",
              {issue_valid, lane_mask}, 64'd0);
        rst_n = 1'b1;
        check(!issue_valid && lane_mask == '0 && slice_idx == 2'd3, "R1",
              "outputs after release", {issue_valid, lane_mask, slice_idx}, 64'd3);
        mon_en = 1'b1;

        // R8: nothing valid -> bubble
        slot(1'b0, 0, 0, '0, "R8", 1'b0, 0, 0);

        // R4/R7: lone warp 2, pointer 0 -> warp 2; pointer becomes 3
        set_warp(2, 1'b1, 1, 2, 3, 32'hFFFF_FFFF);
        slot(1'b1, 2, 1, 32'hFFFF_FFFF, "R4", 1'b0, 0, 0);
        // R5: own destination pending -> bubble
        slot(1'b0, 0, 0, '0, "R5", 1'b0, 0, 0);
        // R5: writeback landing on the choice edge does not help that choice
        slot(1'b0, 0, 0, '0, "R5", 1'b1, 2, 1);
        // R5: cleared entry -> warp 2 issues again
        slot(1'b1, 2, 1, 32'hFFFF_FFFF, "R5", 1'b0, 0, 0);

        // R7/R3: pointer 3 -> 5, 6, then wrap to 1; empty slices keep their clock
        set_warp(2, 1'b0, 1, 2, 3, '0);
        set_warp(5, 1'b1, 4, 0, 1, 32'h1200_3400);
        set_warp(6, 1'b1, 5, 6, 7, 32'hA5A5_A5A5);
        set_warp(1, 1'b1, 6, 0, 2, 32'h0000_0000);
        slot(1'b1, 5, 4, 32'h1200_3400, "R3", 1'b0, 0, 0);
        slot(1'b1, 6, 5, 32'hA5A5_A5A5, "R7", 1'b0, 0, 0);
        slot(1'b1, 1, 6, 32'h0000_0000, "R3", 1'b0, 0, 0);
        // R8: all blocked, pointer stays 2
        slot(1'b0, 0, 0, '0, "R8", 1'b0, 0, 0);

        // R5: writeback to the wrong warp leaves warp 5 blocked
        writeback(1, 4);
        // R6: warp 3 reads tag 5, pending only for warp 6
        set_warp(3, 1'b1, 2, 5, 5, 32'h0F0F_0F0F);
        slot(1'b1, 3, 2, 32'h0F0F_0F0F, "R6", 1'b0, 0, 0);
        slot(1'b0, 0, 0, '0, "R5", 1'b0, 0, 0);

        // R5: correct writeback releases warp 5 (pointer 4 -> 5)
        writeback(5, 4);
        slot(1'b1, 5, 4, 32'h1200_3400, "R5", 1'b0, 0, 0);
        slot(1'b0, 0, 0, '0, "R8", 1'b0, 0, 0);

        // R8/R7: bubble kept pointer at 6, so 6 wins over 5
        writeback(6, 5);
        writeback(5, 4);
        slot(1'b1, 6, 5, 32'hA5A5_A5A5, "R8", 1'b0, 0, 0);
        // R7: pointer 7 wraps past 0..4 to 5
        slot(1'b1, 5, 4, 32'h1200_3400, "R7", 1'b0, 0, 0);

        wait (exp_q.size() == 0);
        repeat (4) @(posedge clk);
        mon_en = 1'b0;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule